// File: doc/BRIEF.md
# 4:2:2 Video Stream Formatter

The formatter takes a digitizer's luma bus and its chroma bus, on which Cb and Cr take turns on successive pixels. It merges them into one 8-bit byte stream that runs at twice the pixel rate. Each line is framed with four-byte start-of-active-video (SAV) and end-of-active-video (EAV) timing codes, so a downstream capture engine finds exactly the configured number of pixels between them. The block runs on the double-rate clock. It takes one pixel on each pulse of a pixel-rate enable and emits the two bytes for that pixel on the next two clock cycles.

Horizontal and vertical counters step once per pixel slot. A line opens with its EAV code, then blanking fill, then its SAV code, then the active pixels. A frame opens with the vertical-blanking lines and then the active lines. All four lengths are parameters, so a line of 512 pixels instead of 1024 needs only a parameter override.

Top module: `video422_framer`

## Requirements
- R1: While `rst` is high at a clock edge, `byte_out` becomes 0x00 and `byte_valid` becomes 0, and both counters return to slot 0 of line 0. The first pixel slot after reset therefore carries the first half of an EAV code (0xFF, 0x00) of a vertical-blanking line.
- R2: When `pix_en` is high at edge k, the first byte of that pixel slot is on `byte_out` after edge k and the second byte is there after edge k+1. `byte_valid` is high after both edges and low after any edge where `pix_en` was low at that edge and also at the edge before.
- R3: In an active slot (slot index at least H_BLANK on a line at or after V_BLANK), the first byte is the sampled chroma byte and the second byte is the sampled luma byte. This gives the order Cb, Y, Cr, Y when chroma alternates.
- R4: Slots 0 and 1 of every line carry the EAV code and slots H_BLANK-2 and H_BLANK-1 carry the SAV code. Each code is the byte sequence 0xFF, 0x00, 0x00, XY. In XY, bit 7 is 1, bit 6 is F, bit 5 is V, and bit 4 is H, which is 1 for EAV and 0 for SAV.
- R5: The low nibble of XY is the protection set {V^H, F^H, F^V, F^V^H}, bits 3 down to 0.
- R6: Slots 2 to H_BLANK-3 carry blanking fill: first byte 0x80, second byte 0x10.
- R7: On an active line exactly 2*ACT_PIX bytes lie between the last byte of SAV and the first byte of EAV.
- R8: Lines 0 to V_BLANK-1 carry V=1 in both of their codes and emit fill (0x80, 0x10) in their active slots. All later lines carry V=0.
- R9: A line has H_BLANK+ACT_PIX slots and a frame has V_BLANK+ACT_LINES lines, after which the counters wrap to slot 0 of line 0.
- R10: F in each XY byte equals `field_in` as sampled in the slot that carries that XY byte.
- R11: An instance built with a different ACT_PIX follows R3 to R7 with its own count and needs no source change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-rate enable, one pulse per pixel slot |
| luma_in | input | 8 | Luma sample |
| chroma_in | input | 8 | Chroma sample, Cb and Cr on alternate pixels |
| field_in | input | 1 | Field flag copied into timing codes |
| byte_out | output | 8 | Interleaved double-rate byte stream |
| byte_valid | output | 1 | High on every emitted byte |

## Verification
The assertions take for granted that `pix_en` is never high on two adjacent edges. They also take for granted that the chroma and field inputs hold still at each sampling edge, so the byte that appears one edge after a pulse can be traced to that pulse alone. The bench drives every input at the falling edge and raises `pix_en` on alternate cycles only. Its one departure is a deliberate extra idle cycle, which lengthens the gap between pulses and never shortens it. The bench flips the field flag mid-frame to exercise F in codes of both polarities.

// File: rtl/video422_framer.sv
module video422_framer #(
  parameter int ACT_PIX   = 1024,
  parameter int H_BLANK   = 280,
  parameter int ACT_LINES = 768,
  parameter int V_BLANK   = 38
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pix_en,
  input  logic [7:0] luma_in,
  input  logic [7:0] chroma_in,
  input  logic       field_in,
  output logic [7:0] byte_out,
  output logic       byte_valid
);
  localparam int HTOT = ACT_PIX + H_BLANK;
  localparam int VTOT = ACT_LINES + V_BLANK;
  localparam int HW = $clog2(HTOT);
  localparam int VW = $clog2(VTOT);
  localparam logic [HW-1:0] H_LAST  = HW'(HTOT - 1);
  localparam logic [HW-1:0] H_SAV   = HW'(H_BLANK - 2);
  localparam logic [HW-1:0] H_ACT   = HW'(H_BLANK);
  localparam logic [VW-1:0] V_LAST  = VW'(VTOT - 1);
  localparam logic [VW-1:0] V_ACT   = VW'(V_BLANK);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [7:0]    second_q;
  logic          pend_q;
  logic [7:0]    b0, b1, xy;

  wire in_eav  = hcnt < HW'(2);
  wire in_sav  = (hcnt >= H_SAV) && (hcnt < H_ACT);
  wire in_act  = hcnt >= H_ACT;
  wire vblank  = vcnt < V_ACT;
  wire f = field_in;
  wire v = vblank;
  wire h = in_eav;

  assign xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};

  always_comb begin
    if (in_eav || in_sav) begin
      b0 = hcnt[0] ? 8'h00 : 8'hFF;
      b1 = hcnt[0] ? xy    : 8'h00;
    end else if (in_act && !vblank) begin
      b0 = chroma_in;
      b1 = luma_in;
    end else begin
      b0 = 8'h80;
      b1 = 8'h10;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt       <= '0;
      vcnt       <= '0;
      byte_out   <= 8'h00;
      byte_valid <= 1'b0;
      second_q   <= 8'h00;
      pend_q     <= 1'b0;
    end else begin
      byte_valid <= pix_en | pend_q;
      pend_q     <= pix_en;
      if (pix_en) begin
        byte_out <= b0;
        second_q <= b1;
        if (hcnt == H_LAST) begin
          hcnt <= '0;
          vcnt <= (vcnt == V_LAST) ? '0 : vcnt + VW'(1);
        end else begin
          hcnt <= hcnt + HW'(1);
        end
      end else if (pend_q) begin
        byte_out <= second_q;
      end
    end
  end
endmodule

// File: rtl/video422_framer_chk.sv
module video422_framer_chk #(
  parameter int ACT_PIX   = 1024,
  parameter int H_BLANK   = 280,
  parameter int ACT_LINES = 768,
  parameter int V_BLANK   = 38,
  parameter int HW        = 11,
  parameter int VW        = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic [7:0]    chroma_in,
  input logic [7:0]    byte_out,
  input logic          byte_valid,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt
);
  localparam logic [HW-1:0] C_HTOT = HW'(ACT_PIX + H_BLANK);
  localparam logic [VW-1:0] C_VTOT = VW'(ACT_LINES + V_BLANK);
  localparam logic [HW-1:0] C_HSAV = HW'(H_BLANK - 2);
  localparam logic [HW-1:0] C_HACT = HW'(H_BLANK);
  localparam logic [VW-1:0] C_VACT = VW'(V_BLANK);

  a_r2_valid_after_pulse: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> byte_valid);

  a_r2_valid_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !$past(pix_en)) |-> $past(pix_en, 2));

  a_r3_chroma_first: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hcnt >= C_HACT && vcnt >= C_VACT) |=> byte_out == $past(chroma_in));

  a_r4_code_lead: assert property (@(posedge clk) disable iff (rst)
    (pix_en && (hcnt == '0 || hcnt == C_HSAV)) |=> byte_out == 8'hFF);

  a_r6_fill: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hcnt >= HW'(2) && hcnt < C_HSAV) |=> byte_out == 8'h80);

  a_r8_vbit: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hcnt == HW'(1) && vcnt < C_VACT) |-> ##2 byte_out[5]);

  a_r9_hrange: assert property (@(posedge clk) disable iff (rst)
    hcnt < C_HTOT);

  a_r9_vrange: assert property (@(posedge clk) disable iff (rst)
    vcnt < C_VTOT);
endmodule

bind video422_framer video422_framer_chk #(
  .ACT_PIX(ACT_PIX), .H_BLANK(H_BLANK), .ACT_LINES(ACT_LINES),
  .V_BLANK(V_BLANK), .HW(HW), .VW(VW)
) chk_i (
  .clk(clk), .rst(rst), .pix_en(pix_en), .chroma_in(chroma_in),
  .byte_out(byte_out), .byte_valid(byte_valid), .hcnt(hcnt), .vcnt(vcnt)
);

// File: tb/video422_framer_tb_top.sv
`timescale 1ns/1ps
module video422_framer_tb_top;
  localparam int AP1 = 8,  HB1 = 6, AL1 = 3, VB1 = 2;
  localparam int AP2 = 12, HB2 = 6, AL2 = 3, VB2 = 2;
  localparam logic [15:0] PATS [8] = '{
    16'h1A_55, 16'hEB_F0, 16'h10_80, 16'h7F_01,
    16'hC3_3C, 16'h00_FF, 16'hFE_7E, 16'h42_99};

  logic clk = 1'b0, rst = 1'b1, pix_en = 1'b0, field_in = 1'b0;
  logic [7:0] luma_in = 8'h00, chroma_in = 8'h00;
  logic [7:0] out1, out2;
  logic val1, val2;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  video422_framer #(.ACT_PIX(AP1), .H_BLANK(HB1), .ACT_LINES(AL1), .V_BLANK(VB1)) dut_i (
    .clk(clk), .rst(rst), .pix_en(pix_en), .luma_in(luma_in), .chroma_in(chroma_in),
    .field_in(field_in), .byte_out(out1), .byte_valid(val1));

  video422_framer #(.ACT_PIX(AP2), .H_BLANK(HB2), .ACT_LINES(AL2), .V_BLANK(VB2)) dut2_i (
    .clk(clk), .rst(rst), .pix_en(pix_en), .luma_in(luma_in), .chroma_in(chroma_in),
    .field_in(field_in), .byte_out(out2), .byte_valid(val2));

  function automatic logic [7:0] code_xy(logic f, logic v, logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [15:0] model(int h, int v, int hb, int vb,
                                        logic f, logic [7:0] y, logic [7:0] c);
    logic vbl = (v < vb);
    if (h < 2 || (h >= hb - 2 && h < hb)) begin
      if (h % 2 == 0) return 16'hFF00;
      return {8'h00, code_xy(f, vbl, h < 2)};
    end
    if (h >= hb && !vbl) return {c, y};
    return 16'h8010;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_pix(input logic [7:0] y, input logic [7:0] c, input logic f,
                        output logic [15:0] p1, output logic [15:0] p2,
                        output logic [3:0] vv);
    pix_en = 1'b1; luma_in = y; chroma_in = c; field_in = f;
    @(negedge clk);
    pix_en = 1'b0;
    p1[15:8] = out1; p2[15:8] = out2; vv[3] = val1; vv[2] = val2;
    @(negedge clk);
    p1[7:0] = out1; p2[7:0] = out2; vv[1] = val1; vv[0] = val2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] p1, p2, e1, e2;
    logic [3:0] vv;
    logic [7:0] hist [4];
    int h1 = 0, v1 = 0, h2 = 0, v2 = 0;
    int nbyte = 0, sav_end = -1, gaps = 0;
    logic f;

    repeat (3) @(negedge clk);
    chk("R1 reset byte_out", {24'h0, out1}, 32'h00);
    chk("R1 reset byte_valid", {31'h0, val1}, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < 200; k++) begin
      f = (k / 45) % 2 == 1;
      do_pix(PATS[k % 8][15:8], PATS[k % 8][7:0], f, p1, p2, vv);
      e1 = model(h1, v1, HB1, VB1, f, PATS[k % 8][15:8], PATS[k % 8][7:0]);
      e2 = model(h2, v2, HB2, VB2, f, PATS[k % 8][15:8], PATS[k % 8][7:0]);
      chk($sformatf("R3 R4 R5 R6 R8 R10 slot h%0d v%0d", h1, v1), {16'h0, p1}, {16'h0, e1});
      chk($sformatf("R11 R9 slot h%0d v%0d", h2, v2), {16'h0, p2}, {16'h0, e2});
      chk("R2 byte_valid pair", {28'h0, vv}, 32'hF);
      h1++; if (h1 == AP1 + HB1) begin h1 = 0; v1 = (v1 + 1) % (AL1 + VB1); end
      h2++; if (h2 == AP2 + HB2) begin h2 = 0; v2 = (v2 + 1) % (AL2 + VB2); end
      for (int b = 0; b < 2; b++) begin
        hist[0] = hist[1]; hist[1] = hist[2]; hist[2] = hist[3];
        hist[3] = (b == 0) ? p2[15:8] : p2[7:0];
        if (nbyte >= 3 && hist[0] == 8'hFF && hist[1] == 8'h00 && hist[2] == 8'h00
            && hist[3][7]) begin
          if (!hist[3][4] && !hist[3][5]) sav_end = nbyte;
          else if (hist[3][4] && sav_end >= 0) begin
            chk("R7 bytes between SAV and EAV", (nbyte - 3) - sav_end - 1, 2 * AP2);
            gaps++;
            sav_end = -1;
          end
        end
        nbyte++;
      end
    end
    chk("R7 active lines measured", {31'h0, gaps > 0}, 32'h1);

    @(negedge clk);
    chk("R2 valid low after idle cycle", {31'h0, val1}, 32'h0);

    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset byte_out", {24'h0, out1}, 32'h00);
    chk("R1 mid-run reset byte_valid", {31'h0, val1}, 32'h0);
    rst = 1'b0;
    do_pix(8'h33, 8'h44, 1'b1, p1, p2, vv);
    chk("R1 first slot after reset", {16'h0, p1}, 32'hFF00);
    do_pix(8'h33, 8'h44, 1'b1, p1, p2, vv);
    chk("R1 R5 R10 EAV XY after reset", {16'h0, p1}, {24'h0, code_xy(1'b1, 1'b1, 1'b1)});
    chk("R5 XY constant F1 V1 H1", {16'h0, p1}, 32'h00F1);

    summary();
  end
endmodule